// File: doc/BRIEF.md
# Timing controller register read port

This block is the processor-facing read side of a CRT timing controller's register file. A processor selects a register by a 5-bit index. It then reads either through the data port or through the status port. The block returns one byte, formed combinationally from four things: the index, the port choice, a variant code, and the values it holds. The variant code picks among five controller flavours, and each flavour has its own read rules.

The standard flavours (codes 0 to 2) let only the cursor address and the light-pen latch be read back. Every other register reads as zero. The folded flavours (codes 3 and 4) look only at the three low index bits, and they map those bits onto a fixed set of eight registers. On these flavours the two cursor-raster slots return the status byte. The block also holds the write path for the display start and cursor address registers. That path captures on the bus clock.

Top module: `tc_read_port`

## Requirements
- R1: With variant 0, 1 or 2 and the data port selected (reg_sel_i=1), index 14 returns the cursor address high register and index 15 returns the cursor address low register.
- R2: With variant 0, 1 or 2 and the data port selected, index 16 returns the light-pen high latch zero-extended to 8 bits, and index 17 returns the light-pen low latch.
- R3: With variant 0, 1 or 2 and the data port selected, any index other than 14 to 17 returns 0x00.
- R4: On the status port (reg_sel_i=0), variant 1 returns status_i. Variants 0 and 2 return 0x00.
- R5: With variant 3 or 4, only idx_i[2:0] takes part in a read, so indices 4, 12 and 20 read alike. Folded values 0 to 7 select, in this order: light-pen high, light-pen low, cursor-raster start, cursor-raster end, display start high, display start low, cursor address high, cursor address low.
- R6: With variant 3 or 4, folded values 2 and 3 return status_i. A write to index 10 or 11 does not change what they return.
- R7: With variant 3 or 4, the status port returns the same byte as the data port for the same index.
- R8: Bits 7:6 read as 0 for display start high, cursor address high and light-pen high. Writes keep only bits 5:0 of those two registers.
- R9: A write (wr_en_i=1) to index 12, 13, 14 or 15 is captured at the rising clock edge and is readable after it, not before. A write to any other index changes no read value. Reset clears all four registers to 0x00.
- R10: The read path is combinational: a change of idx_i, reg_sel_i, variant_i or status_i shows on rd_data_o without a clock edge.
- R11: Variant codes 5, 6 and 7 read like variant 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock for the write path |
| rst_ni | input | 1 | Active-low asynchronous reset |
| variant_i | input | 3 | Controller flavour code |
| reg_sel_i | input | 1 | 1 = data port, 0 = status port |
| idx_i | input | 5 | Selected register index, for reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| lp_hi_i | input | 6 | Light-pen latch, high part |
| lp_lo_i | input | 8 | Light-pen latch, low part |
| status_i | input | 8 | Status byte |
| rd_data_o | output | 8 | Read data |

## Verification
A corrupted stored register reaches rd_data_o only when a read selects it. Once selected, the error shows in the same cycle, because nothing sits between the store and the output. A wrong index decode shows at once on every access to the affected index, so the bench reads each index class under each variant against a known stored pattern. A misplaced write enable shows one edge after the write: either the targeted register fails to change, or some other readable value changes.

// File: rtl/tc_rd_pkg.sv
package tc_rd_pkg;
  localparam int IDX_W    = 5;
  localparam int DATA_W   = 8;
  localparam int VAR_W    = 3;
  localparam int NARROW_W = 6;
  localparam int BASE_IDX = 12;   // first stored register
  localparam int N_STORE  = 4;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_STAT, SRC_SA_HI, SRC_SA_LO,
    SRC_CA_HI, SRC_CA_LO, SRC_LP_HI, SRC_LP_LO
  } src_e;

  function automatic logic is_folded(input logic [VAR_W-1:0] v);
    return (v == VAR_W'(3)) || (v == VAR_W'(4));
  endfunction
endpackage

// File: rtl/tc_reg_store.sv
module tc_reg_store
  import tc_rd_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = DATA_W,
  parameter int NW = NARROW_W,
  parameter int NS = N_STORE,
  parameter int BI = BASE_IDX
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [DW-1:0]          wr_data_i,
  output logic [NS-1:0][DW-1:0]  regs_o
);
  for (genvar g = 0; g < NS; g++) begin : g_reg
    // even offsets are the narrow high halves
    localparam int W = (g % 2 == 0) ? NW : DW;
    logic [W-1:0] q;
    logic         hit;
    assign hit = wr_en_i && (wr_idx_i == IW'(BI + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= wr_data_i[W-1:0];
    end
    assign regs_o[g] = DW'(q);
  end
endmodule

// File: rtl/tc_idx_map.sv
module tc_idx_map
  import tc_rd_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int VW = VAR_W
) (
  input  logic [VW-1:0] variant_i,
  input  logic          reg_sel_i,
  input  logic [IW-1:0] idx_i,
  output src_e          src_o
);
  logic folded;
  assign folded = is_folded(variant_i);

  always_comb begin
    src_o = SRC_ZERO;
    if (folded) begin
      // both ports decode the same on folded flavours
      unique case (idx_i[2:0])
        3'd0: src_o = SRC_LP_HI;
        3'd1: src_o = SRC_LP_LO;
        3'd2: src_o = SRC_STAT;
        3'd3: src_o = SRC_STAT;
        3'd4: src_o = SRC_SA_HI;
        3'd5: src_o = SRC_SA_LO;
        3'd6: src_o = SRC_CA_HI;
        default: src_o = SRC_CA_LO;
      endcase
    end else if (!reg_sel_i) begin
      src_o = (variant_i == VW'(1)) ? SRC_STAT : SRC_ZERO;
    end else begin
      if      (idx_i == IW'(14)) src_o = SRC_CA_HI;
      else if (idx_i == IW'(15)) src_o = SRC_CA_LO;
      else if (idx_i == IW'(16)) src_o = SRC_LP_HI;
      else if (idx_i == IW'(17)) src_o = SRC_LP_LO;
      else                       src_o = SRC_ZERO;
    end
  end
endmodule

// File: rtl/tc_rd_mux.sv
module tc_rd_mux
  import tc_rd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NW = NARROW_W,
  parameter int NS = N_STORE
) (
  input  src_e                  src_i,
  input  logic [NS-1:0][DW-1:0] regs_i,
  input  logic [NW-1:0]         lp_hi_i,
  input  logic [DW-1:0]         lp_lo_i,
  input  logic [DW-1:0]         status_i,
  output logic [DW-1:0]         rd_data_o
);
  always_comb begin
    unique case (src_i)
      SRC_STAT:  rd_data_o = status_i;
      SRC_SA_HI: rd_data_o = regs_i[0];
      SRC_SA_LO: rd_data_o = regs_i[1];
      SRC_CA_HI: rd_data_o = regs_i[2];
      SRC_CA_LO: rd_data_o = regs_i[3];
      SRC_LP_HI: rd_data_o = DW'(lp_hi_i);
      SRC_LP_LO: rd_data_o = lp_lo_i;
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/tc_read_port.sv
module tc_read_port
  import tc_rd_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = DATA_W,
  parameter int VW = VAR_W,
  parameter int NW = NARROW_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] variant_i,
  input  logic          reg_sel_i,
  input  logic [IW-1:0] idx_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [NW-1:0] lp_hi_i,
  input  logic [DW-1:0] lp_lo_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] rd_data_o
);
  logic [N_STORE-1:0][DW-1:0] regs;
  src_e                       src;

  tc_reg_store #(.IW(IW), .DW(DW), .NW(NW), .NS(N_STORE), .BI(BASE_IDX)) i_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i(idx_i), .wr_data_i, .regs_o(regs)
  );

  tc_idx_map #(.IW(IW), .VW(VW)) i_map (
    .variant_i, .reg_sel_i, .idx_i, .src_o(src)
  );

  tc_rd_mux #(.DW(DW), .NW(NW), .NS(N_STORE)) i_mux (
    .src_i(src), .regs_i(regs), .lp_hi_i, .lp_lo_i, .status_i, .rd_data_o
  );
endmodule

// File: rtl/tc_read_port_chk.sv
module tc_read_port_chk #(
  parameter int IW = 5,
  parameter int DW = 8,
  parameter int VW = 3,
  parameter int NW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [VW-1:0] variant_i,
  input logic          reg_sel_i,
  input logic [IW-1:0] idx_i,
  input logic          wr_en_i,
  input logic [DW-1:0] wr_data_i,
  input logic [NW-1:0] lp_hi_i,
  input logic [DW-1:0] lp_lo_i,
  input logic [DW-1:0] status_i,
  input logic [DW-1:0] rd_data_o
);
  logic fold, std;
  assign fold = (variant_i == VW'(3)) || (variant_i == VW'(4));
  assign std  = !fold;

  p_wo_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (std && reg_sel_i && (idx_i < IW'(14) || idx_i > IW'(17))) |-> rd_data_o == '0);

  p_lp_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (std && reg_sel_i && idx_i == IW'(16)) |-> rd_data_o == DW'(lp_hi_i));

  p_stat_port_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (variant_i == VW'(1) && !reg_sel_i) |-> rd_data_o == status_i);

  p_stat_fold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fold && idx_i[2:1] == 2'b01) |-> rd_data_o == status_i);

  p_narrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fold && (idx_i[2:0] == 3'd0 || idx_i[2:0] == 3'd4 || idx_i[2:0] == 3'd6))
      |-> rd_data_o[DW-1:NW] == '0);

  p_wr_vis_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && idx_i == IW'(13))
      |=> (!(fold && idx_i[2:0] == 3'd5) || rd_data_o == $past(wr_data_i)));
endmodule

bind tc_read_port tc_read_port_chk #(.IW(IW), .DW(DW), .VW(VW), .NW(NW)) i_chk (
  .clk_i, .rst_ni, .variant_i, .reg_sel_i, .idx_i, .wr_en_i, .wr_data_i,
  .lp_hi_i, .lp_lo_i, .status_i, .rd_data_o
);

// File: tb/test_tc_read_port.sv
module test_tc_read_port;
  localparam time CLK_P = 8ns;
  localparam int  NV = 27;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] variant_i = '0;
  logic       reg_sel_i = 1'b1;
  logic [4:0] idx_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [5:0] lp_hi_i = 6'h15;
  logic [7:0] lp_lo_i = 8'hE4;
  logic [7:0] status_i = 8'h6B;
  logic [7:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  tc_read_port i_tc_read_port (.*);

  // {req, variant, reg_sel, idx, expected}; store holds 07,5A,3F,81
  localparam logic [20:0] VEC [NV] = '{
    {4'd1,  3'd0, 1'b1, 5'd14, 8'h3F},  // R1 R8
    {4'd1,  3'd0, 1'b1, 5'd15, 8'h81},  // R1
    {4'd2,  3'd0, 1'b1, 5'd16, 8'h15},  // R2
    {4'd2,  3'd2, 1'b1, 5'd17, 8'hE4},  // R2
    {4'd3,  3'd0, 1'b1, 5'd12, 8'h00},  // R3
    {4'd3,  3'd1, 1'b1, 5'd13, 8'h00},  // R3
    {4'd3,  3'd0, 1'b1, 5'd20, 8'h00},  // R3
    {4'd1,  3'd2, 1'b1, 5'd14, 8'h3F},  // R1
    {4'd3,  3'd1, 1'b1, 5'd10, 8'h00},  // R3
    {4'd4,  3'd1, 1'b0, 5'd5,  8'h6B},  // R4
    {4'd4,  3'd0, 1'b0, 5'd14, 8'h00},  // R4
    {4'd4,  3'd2, 1'b0, 5'd16, 8'h00},  // R4
    {4'd5,  3'd3, 1'b1, 5'd0,  8'h15},  // R5
    {4'd5,  3'd3, 1'b1, 5'd1,  8'hE4},  // R5
    {4'd6,  3'd3, 1'b1, 5'd2,  8'h6B},  // R6
    {4'd6,  3'd4, 1'b1, 5'd11, 8'h6B},  // R6
    {4'd5,  3'd3, 1'b1, 5'd4,  8'h07},  // R5 R8
    {4'd5,  3'd4, 1'b1, 5'd12, 8'h07},  // R5
    {4'd5,  3'd4, 1'b1, 5'd20, 8'h07},  // R5
    {4'd5,  3'd3, 1'b1, 5'd5,  8'h5A},  // R5
    {4'd5,  3'd4, 1'b1, 5'd6,  8'h3F},  // R5
    {4'd5,  3'd4, 1'b1, 5'd31, 8'h81},  // R5
    {4'd7,  3'd3, 1'b0, 5'd13, 8'h5A},  // R7
    {4'd7,  3'd4, 1'b0, 5'd8,  8'h15},  // R7
    {4'd11, 3'd5, 1'b1, 5'd14, 8'h3F},  // R11
    {4'd11, 3'd7, 1'b0, 5'd5,  8'h00},  // R11
    {4'd11, 3'd6, 1'b1, 5'd4,  8'h00}   // R11
  };

  task automatic check(input int req, input logic [7:0] exp);
    n_chk++;
    if (rd_data_o !== exp) begin
      n_fail++;
      $display("FAIL R%0d: rd_data_o=%02h expected %02h (var=%0d sel=%0b idx=%0d)",
               req, rd_data_o, exp, variant_i, reg_sel_i, idx_i);
    end
  endtask

  task automatic wr(input logic [4:0] idx, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; idx_i = idx; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] v, input logic s, input logic [4:0] idx);
    @(negedge clk_i);
    variant_i = v; reg_sel_i = s; idx_i = idx;
    #1;
  endtask

  initial begin
    // reset state, R9
    #1;
    variant_i = 3'd3; idx_i = 5'd4; #1; check(9, 8'h00);
    idx_i = 5'd7; #1; check(9, 8'h00);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    rd(3'd3, 1'b1, 5'd6); check(9, 8'h00);

    wr(5'd12, 8'hC7);
    wr(5'd13, 8'h5A);
    wr(5'd14, 8'hFF);
    wr(5'd15, 8'h81);
    // ignored targets, R9 / R6
    wr(5'd10, 8'hFF);
    wr(5'd11, 8'hEE);
    wr(5'd0,  8'hFF);
    wr(5'd30, 8'hFF);
    wr(5'd28, 8'h00);  // folds to 4 on read, must not write

    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][16:14], VEC[i][13], VEC[i][12:8]);
      check(int'(VEC[i][20:17]), VEC[i][7:0]);
    end

    // R10: combinational path, no edge between changes
    @(negedge clk_i);
    variant_i = 3'd0; reg_sel_i = 1'b1; idx_i = 5'd16;
    #1 check(10, 8'h15);
    idx_i = 5'd15;
    #1 check(10, 8'h81);
    variant_i = 3'd4; idx_i = 5'd3; status_i = 8'h90;
    #1 check(10, 8'h90);
    status_i = 8'h0C;
    #1 check(6, 8'h0C);
    reg_sel_i = 1'b0;
    #1 check(7, 8'h0C);

    // R9: write visible after the edge, not before
    @(negedge clk_i);
    variant_i = 3'd3; reg_sel_i = 1'b1; idx_i = 5'd13;
    wr_en_i = 1'b1; wr_data_i = 8'h33;
    #1 check(9, 8'h5A);
    @(posedge clk_i); #1;
    check(9, 8'h33);
    @(negedge clk_i);
    wr_en_i = 1'b0;

    // R8: narrow write keeps low six bits
    wr(5'd12, 8'hBE);
    rd(3'd4, 1'b1, 5'd4); check(8, 8'h3E);
    // R6: status slot unaffected by write to index 10
    wr(5'd10, 8'h55);
    rd(3'd3, 1'b1, 5'd10); check(6, 8'h0C);
    // R1: cursor low unchanged by ignored writes
    rd(3'd1, 1'b1, 5'd15); check(1, 8'h81);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule